// File: doc/BRIEF.md
# Sampled Sine Modulation Reference

This block supplies the slowly varying modulating value for a sine-triangle PWM stage. A fundamental period of the sine is stored as a short table of unsigned samples. Each sample strobe moves a phase index one step through the table. The sample the index now points at is registered on the output together with a one-cycle valid pulse, so that a downstream compare register can latch it.

The sine is lifted by half of the carrier period so that every value lies between zero and the carrier period. The default carrier period is 6250, which gives a mid-scale of 3125. With the default 25 samples and a 1.25 kHz strobe, one full table pass takes 20 ms, which is a 50 Hz fundamental. The table length and the strobe rate set the output frequency. The table amplitude sets the output voltage amplitude. A saturating stage keeps every value inside the carrier range even if a table entry rounds outside it.

Top module: `sine_ref_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next output state is `ref_out` = 3125 (mid-scale, phase index 0) and `ref_valid` = 0.
- R2: `sample_stb` is sampled at every rising edge. Each edge at which it is high is one sample. `ref_valid` is high in the cycle after such an edge and low in the cycle after every edge at which the strobe was low.
- R3: The k-th sample after reset (k = 1, 2, ...) sets `ref_out` to round(3125 + 3125*sin(2*pi*(k mod 25)/25)), with halves rounded up.
- R4: The phase index wraps from 24 back to 0. The 25th sample after reset gives 3125 again, and the sequence then repeats with period 25.
- R5: `ref_out` never exceeds 6250. Values are unsigned and clamped to the range 0 to 6250.
- R6: Edges at which `sample_stb` is low leave `ref_out` unchanged.
- R7: A strobe held high on consecutive edges advances one table step per edge, with `ref_valid` high in each following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_stb | input | 1 | Sample-rate strobe, one step per high edge |
| ref_out | output | 16 | Unsigned modulation reference, 0 to carrier period |
| ref_valid | output | 1 | High for one cycle when `ref_out` carries a new sample |

## Verification
Every result is due exactly one rising edge after its cause. A strobe or reset seen at one edge appears on `ref_out` and `ref_valid` after that same edge, and there is no extra pipeline stage. The bench drives inputs at falling edges and reads the outputs at the next falling edge. Each read therefore lands half a period after the edge that produced the value. For idle stretches the bench reads at every falling edge and confirms that `ref_valid` stays low and `ref_out` stays fixed. The expected values come from the sine formula in R3, evaluated in the bench against its own sample count.

// File: rtl/sine_ref_pkg.sv
// Shared definitions for the sine modulation reference.
// Holds the entry calculation used to fill the sample table at elaboration.
package sine_ref_pkg;

    // Rounded sample k of n around a half-scale offset of peak/2 (halves round up).
    function automatic int sine_entry(input int k, input int n, input int peak);
        real half;
        real ang;
        half = real'(peak) / 2.0;
        ang  = 2.0 * 3.14159265358979 * real'(k) / real'(n);
        return $rtoi($floor(half + half * $sin(ang) + 0.5));
    endfunction

endpackage

// File: rtl/sine_phase_ctr.sv
// Phase index for the sample table.
// Steps by one on every strobe and wraps from SAMPLES-1 to 0.
// Assumes SAMPLES >= 2. Also offers the index that the next strobe will load.
module sine_phase_ctr #(
    parameter int SAMPLES = 25,
    localparam int PH_W = $clog2(SAMPLES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    output logic [PH_W-1:0] phase_q,
    output logic [PH_W-1:0] phase_next
);
    localparam logic [PH_W-1:0] LAST = PH_W'(SAMPLES - 1);

    // Successor index with wrap at the end of the table.
    always_comb begin
        phase_next = (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end

    // Index register: cleared by reset, advanced on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (step)
            phase_q <= phase_next;
    end

    // R4: the index always points inside the table.
    a_r4_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= LAST);

    // R4: a strobe on the last entry returns the index to the start.
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && phase_q == LAST) |=> phase_q == '0);

endmodule

// File: rtl/sine_table.sv
// One fundamental period of an offset sine, held as constant entries.
// The entries are built at elaboration, so no storage is written at run time.
// The lookup is combinational. Entries are signed and wide enough to show rounding overshoot.
module sine_table #(
    parameter int SAMPLES     = 25,
    parameter int CARRIER_MAX = 6250,
    parameter int ENT_W       = 18,
    localparam int PH_W = $clog2(SAMPLES)
) (
    input  logic [PH_W-1:0]          idx,
    output logic signed [ENT_W-1:0]  entry
);
    logic signed [ENT_W-1:0] rom [SAMPLES];

    // One constant entry per phase step.
    for (genvar i = 0; i < SAMPLES; i++) begin : g_ent
        localparam int VAL = sine_ref_pkg::sine_entry(i, SAMPLES, CARRIER_MAX);
        assign rom[i] = ENT_W'(VAL);
    end

    // Select the entry for the requested phase (index is kept in range upstream).
    always_comb begin
        entry = rom[idx];
    end

endmodule

// File: rtl/ref_saturate.sv
// Limits a signed table value to the unsigned carrier range [0, CARRIER_MAX].
// Purely combinational. Assumes CARRIER_MAX fits in OUT_W bits.
module ref_saturate #(
    parameter int IN_W        = 18,
    parameter int OUT_W       = 16,
    parameter int CARRIER_MAX = 6250
) (
    input  logic signed [IN_W-1:0] raw,
    output logic [OUT_W-1:0]       sat
);
    localparam logic signed [IN_W-1:0] TOP = IN_W'(CARRIER_MAX);

    // Clip the value at zero below and at the carrier period above.
    always_comb begin
        if (raw < 0)
            sat = '0;
        else if (raw > TOP)
            sat = OUT_W'(CARRIER_MAX);
        else
            sat = raw[OUT_W-1:0];
    end

endmodule

// File: rtl/sine_ref_gen.sv
// Offset sine modulation reference for a sine-triangle PWM.
// On each sample strobe, moves one step through a stored sine period and registers
// the clamped unsigned value with a one-cycle valid pulse.
// Assumes the strobe is synchronous to clk and that each high edge counts as one sample.
module sine_ref_gen #(
    parameter int SAMPLES     = 25,
    parameter int CARRIER_MAX = 6250,
    parameter int REF_W       = 16,
    localparam int PH_W  = $clog2(SAMPLES),
    localparam int ENT_W = REF_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_stb,
    output logic [REF_W-1:0] ref_out,
    output logic             ref_valid
);
    localparam logic [REF_W-1:0] MID = REF_W'(CARRIER_MAX / 2);
    localparam logic [REF_W-1:0] TOP = REF_W'(CARRIER_MAX);

    logic [PH_W-1:0]         phase_q;
    logic [PH_W-1:0]         phase_next;
    logic signed [ENT_W-1:0] entry;
    logic [REF_W-1:0]        clamped;

    sine_phase_ctr #(.SAMPLES(SAMPLES)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (sample_stb),
        .phase_q    (phase_q),
        .phase_next (phase_next)
    );

    sine_table #(
        .SAMPLES     (SAMPLES),
        .CARRIER_MAX (CARRIER_MAX),
        .ENT_W       (ENT_W)
    ) u_table (
        .idx   (phase_next),
        .entry (entry)
    );

    ref_saturate #(
        .IN_W        (ENT_W),
        .OUT_W       (REF_W),
        .CARRIER_MAX (CARRIER_MAX)
    ) u_sat (
        .raw (entry),
        .sat (clamped)
    );

    // Output register: mid-scale on reset, the next sample on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_out   <= MID;
            ref_valid <= 1'b0;
        end else begin
            ref_valid <= sample_stb;
            if (sample_stb)
                ref_out <= clamped;
        end
    end

    // R2: a strobe always yields a valid pulse one cycle later.
    a_r2_valid_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> ref_valid);

    // R2: a valid pulse never appears without a strobe in the cycle before.
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |-> $past(sample_stb));

    // R5: the reference stays within the carrier range.
    a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ref_out <= TOP);

    // R6: without a strobe the output holds.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> $stable(ref_out));

endmodule

// File: tb/sine_ref_gen_test.sv
module sine_ref_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_stb = 1'b0;
    logic [15:0] ref_out;
    logic        ref_valid;

    int total = 0;
    int bad   = 0;
    int k     = 0;   // samples taken since the last reset

    always #2 clk = ~clk;   // 250 MHz

    sine_ref_gen uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .ref_out    (ref_out),
        .ref_valid  (ref_valid)
    );

    function automatic int expect_val(input int n);
        real x;
        x = 3125.0 + 3125.0 * $sin(2.0 * 3.14159265358979 * real'(n % 25) / 25.0);
        return $rtoi($floor(x + 0.5));
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at the falling edge after a strobe edge: expects the next sample.
    task automatic check_sample(input string req);
        k++;
        check({req, " valid"}, int'(ref_valid), 1);
        check({req, " value"}, int'(ref_out), expect_val(k));
        check("R5 range", int'(ref_out <= 16'd6250), 1);
    endtask

    task automatic t_reset;   // R1
        rst_n = 1'b0;
        sample_stb = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset value", int'(ref_out), 3125);
        check("R1 reset valid", int'(ref_valid), 0);
        rst_n = 1'b1;
        k = 0;
    endtask

    task automatic t_spaced(input int n, input int gap);   // R2, R3, R6
        for (int i = 0; i < n; i++) begin
            logic [15:0] held;
            @(negedge clk);
            sample_stb = 1'b1;
            @(negedge clk);
            sample_stb = 1'b0;
            check_sample("R3");
            held = ref_out;
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                check("R2 idle valid", int'(ref_valid), 0);
                check("R6 hold", int'(ref_out), int'(held));
            end
        end
    endtask

    task automatic t_wrap;   // R4
        t_spaced(25 - k, 1);
        check("R4 wrap to mid", int'(ref_out), 3125);
        t_spaced(7, 1);
        check("R4 repeat", int'(ref_out), expect_val(7));
    endtask

    task automatic t_back_to_back(input int n);   // R7
        @(negedge clk);
        sample_stb = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == n - 1) sample_stb = 1'b0;
            check_sample("R7");
        end
        @(negedge clk);
        check("R7 valid drops", int'(ref_valid), 0);
    endtask

    task automatic t_mid_reset;   // R1 during activity
        @(negedge clk);
        rst_n = 1'b0;
        sample_stb = 1'b1;
        @(negedge clk);
        check("R1 mid reset value", int'(ref_out), 3125);
        check("R1 mid reset valid", int'(ref_valid), 0);
        sample_stb = 1'b0;
        rst_n = 1'b1;
        k = 0;
        t_spaced(2, 2);
    endtask

    initial begin
        t_reset();
        t_spaced(3, 3);
        t_wrap();
        t_back_to_back(30);
        t_spaced(4, 5);
        t_mid_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule